// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block gives two independent agents, called the left and right ports, a set of hardware semaphores. They use it to agree on who may use a shared resource. Each semaphore is a single token.

A port claims a token by writing a zero to the semaphore, then reads the semaphore back:

- A zero read back means the port now owns the token.
- A one read back means the other side owns it.

A port that writes a zero while the other side owns the token keeps a pending request. That request is granted as soon as the owner gives the token up.

Each port has its own set of request flags, one per semaphore. Per-semaphore ownership logic turns those flags into grants. It never grants a token to both sides, even when both ports ask for it in the same clock cycle. A tie of that kind is settled in favour of the left port. A port withdraws a pending request, or releases a token it holds, by writing a one.

Real parts of this kind rely on software to free every semaphore at start-up, by writing a one to each from both sides. Here a synchronous reset also clears every request flag, so the block starts in a known state.

Top module: `dual_sema_bank`

## Requirements
- R1: There are eight semaphores, addressed by a 3-bit index. An operation on one semaphore never changes the ownership of another.
- R2: A write is a cycle with select=1 and write-enable=1. A write whose data bit 0 is 0 sets that port's request flag for the indexed semaphore. A write whose data bit 0 is 1 clears the flag, and releases the token if the port holds it.
- R3: A read is a cycle with select=1 and write-enable=0. During a read, every bit of the port's data-out is 0 if that port holds the indexed token, and 1 otherwise. When a port is not reading, its data-out is all ones. A read never changes any request flag or any ownership.
- R4: No semaphore is ever owned by both ports at once.
- R5: A request for a free semaphore is granted at the clock edge that accepts the write. A read by that port in the next cycle returns zero.
- R6: The earlier requester wins. While a port owns a token and keeps its request, the other port's request is recorded but not granted.
- R7: When both ports write a zero to the same free semaphore in the same cycle, exactly one port wins, and that port is the left one. The right port's request stays pending.
- R8: When the owner releases a token and the other port has a pending request, the token passes to the waiting port at that same clock edge. The waiting port's next read returns zero.
- R9: Data-in bits other than bit 0 have no effect on a write.
- R10: A synchronous active-high reset clears all request flags, leaving every semaphore free.
- R11: A waiting port that writes a one withdraws its request. A later release by the owner then leaves the semaphore free instead of handing it over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left port semaphore select |
| l_we | input | 1 | Left port write enable (1 = write, 0 = read) |
| l_idx | input | 3 | Left port semaphore index |
| l_din | input | 16 | Left port write data; only bit 0 is used |
| l_dout | output | 16 | Left port read data, status bit replicated |
| r_sel | input | 1 | Right port semaphore select |
| r_we | input | 1 | Right port write enable (1 = write, 0 = read) |
| r_idx | input | 3 | Right port semaphore index |
| r_din | input | 16 | Right port write data; only bit 0 is used |
| r_dout | output | 16 | Right port read data, status bit replicated |

## Verification
The properties assume that every port input holds a known 0/1 value on each rising edge once reset is released. They also assume that reset is asserted for at least one edge before operation begins, so the flags are never undefined.

The bench drives all select, write-enable, index and data pins on the falling edge, from fully defined values. It holds reset for the first cycles.

The random phase mixes writes of zero, writes of one and reads on both ports. It fills the upper data bits with arbitrary values and often aims both ports at the same index in the same cycle, so ties and hand-overs arise without breaking those assumptions.

// File: rtl/sema_pkg.sv
package sema_pkg;
  // ownership of one token
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sema_req_latch.sv
// Request flags of one port: a write of bit0=0 sets, bit0=1 clears.
module sema_req_latch #(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic               wbit,
  output logic [NUM_SEM-1:0] req,
  output logic [NUM_SEM-1:0] req_nxt
);
  logic wr_en;
  assign wr_en = sel && we;

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_flag
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(i));
    assign req_nxt[i] = hit ? ~wbit : req[i];

    always_ff @(posedge clk) begin
      if (rst) req[i] <= 1'b0;
      else     req[i] <= req_nxt[i];
    end
  end
endmodule

// File: rtl/sema_arbiter.sv
// One owner register per semaphore; the holder keeps the token while its
// request stays set, and a free token goes left first, then right.
module sema_arbiter
  import sema_pkg::*;
#(
  parameter int NUM_SEM = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SEM-1:0] req_l_nxt,
  input  logic [NUM_SEM-1:0] req_r_nxt,
  output logic [NUM_SEM-1:0] own_l,
  output logic [NUM_SEM-1:0] own_r
);
  for (genvar i = 0; i < NUM_SEM; i++) begin : g_tok
    owner_e state, state_nxt;

    always_comb begin
      state_nxt = state;
      unique case (state)
        OWN_LEFT:  if (!req_l_nxt[i]) state_nxt = req_r_nxt[i] ? OWN_RIGHT : OWN_NONE;
        OWN_RIGHT: if (!req_r_nxt[i]) state_nxt = req_l_nxt[i] ? OWN_LEFT : OWN_NONE;
        default: begin
          if (req_l_nxt[i])      state_nxt = OWN_LEFT;
          else if (req_r_nxt[i]) state_nxt = OWN_RIGHT;
          else                   state_nxt = OWN_NONE;
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) state <= OWN_NONE;
      else     state <= state_nxt;
    end

    assign own_l[i] = (state == OWN_LEFT);
    assign own_r[i] = (state == OWN_RIGHT);
  end
endmodule

// File: rtl/sema_read_port.sv
// Status read: 0 on every bit when this port holds the indexed token.
module sema_read_port #(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = $clog2(NUM_SEM),
  parameter int DATA_W  = 16
) (
  input  logic               sel,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_SEM-1:0] own,
  output logic [DATA_W-1:0]  dout
);
  logic held;
  assign held = own[idx];

  always_comb begin
    if (sel && !we) dout = {DATA_W{~held}};
    else            dout = '1;
  end
endmodule

// File: rtl/dual_sema_bank.sv
module dual_sema_bank #(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = $clog2(NUM_SEM),
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_we,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic [DATA_W-1:0] l_din,
  output logic [DATA_W-1:0] l_dout,
  input  logic              r_sel,
  input  logic              r_we,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [DATA_W-1:0] r_din,
  output logic [DATA_W-1:0] r_dout
);
  logic [NUM_SEM-1:0] req_l, req_r, req_l_nxt, req_r_nxt;
  logic [NUM_SEM-1:0] own_l, own_r;

  sema_req_latch #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_req_l (
    .clk(clk), .rst(rst), .sel(l_sel), .we(l_we), .idx(l_idx),
    .wbit(l_din[0]), .req(req_l), .req_nxt(req_l_nxt)
  );

  sema_req_latch #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_req_r (
    .clk(clk), .rst(rst), .sel(r_sel), .we(r_we), .idx(r_idx),
    .wbit(r_din[0]), .req(req_r), .req_nxt(req_r_nxt)
  );

  sema_arbiter #(.NUM_SEM(NUM_SEM)) u_arb (
    .clk(clk), .rst(rst), .req_l_nxt(req_l_nxt), .req_r_nxt(req_r_nxt),
    .own_l(own_l), .own_r(own_r)
  );

  sema_read_port #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_l (
    .sel(l_sel), .we(l_we), .idx(l_idx), .own(own_l), .dout(l_dout)
  );

  sema_read_port #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_r (
    .sel(r_sel), .we(r_we), .idx(r_idx), .own(own_r), .dout(r_dout)
  );
endmodule

// File: rtl/dual_sema_bank_chk.sv
module dual_sema_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = $clog2(NUM_SEM),
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               l_sel,
  input logic               l_we,
  input logic [IDX_W-1:0]   l_idx,
  input logic [DATA_W-1:0]  l_din,
  input logic               r_sel,
  input logic               r_we,
  input logic [IDX_W-1:0]   r_idx,
  input logic [DATA_W-1:0]  r_din,
  input logic [NUM_SEM-1:0] req_l,
  input logic [NUM_SEM-1:0] req_r,
  input logic [NUM_SEM-1:0] own_l,
  input logic [NUM_SEM-1:0] own_r
);
  logic l_take, l_give, r_take, r_give;
  assign l_take = l_sel && l_we && !l_din[0];
  assign l_give = l_sel && l_we &&  l_din[0];
  assign r_take = r_sel && r_we && !r_din[0];
  assign r_give = r_sel && r_we &&  r_din[0];

  // R10: reset frees everything
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (own_l == '0 && own_r == '0 && req_l == '0 && req_r == '0));

  // R4: never two owners
  p_mutex_r4: assert property (@(posedge clk) disable iff (rst)
    (own_l & own_r) == '0);

  // R2: ownership implies a standing request
  p_owner_has_req_r2: assert property (@(posedge clk) disable iff (rst)
    ((own_l & ~req_l) == '0) && ((own_r & ~req_r) == '0));

  // R2: a write of one releases the writer's token
  p_release_r2: assert property (@(posedge clk) disable iff (rst)
    l_give |=> !own_l[$past(l_idx)]);

  // R5: request on a token the right side does not hold is granted
  p_grant_left_r5: assert property (@(posedge clk) disable iff (rst)
    (l_take && !own_r[l_idx]) |=> own_l[$past(l_idx)]);

  p_grant_right_r5: assert property (@(posedge clk) disable iff (rst)
    (r_take && !own_l[r_idx] && !(l_take && l_idx == r_idx)) |=> own_r[$past(r_idx)]);

  // R7: same-cycle tie on a free token goes left
  p_tie_left_r7: assert property (@(posedge clk) disable iff (rst)
    (l_take && r_take && l_idx == r_idx && !own_l[l_idx] && !own_r[l_idx])
      |=> (own_l[$past(l_idx)] && !own_r[$past(l_idx)]));

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    logic lg_i, rg_i;
    assign lg_i = l_give && (l_idx == IDX_W'(i));
    assign rg_i = r_give && (r_idx == IDX_W'(i));

    // R6: holder keeps the token until it releases it
    p_hold_left_r6: assert property (@(posedge clk) disable iff (rst)
      (own_l[i] && !lg_i) |=> own_l[i]);
    p_hold_right_r6: assert property (@(posedge clk) disable iff (rst)
      (own_r[i] && !rg_i) |=> own_r[i]);

    // R8: release with the other side waiting hands the token over
    p_handover_lr_r8: assert property (@(posedge clk) disable iff (rst)
      (own_l[i] && lg_i && req_r[i] && !rg_i) |=> own_r[i]);
    p_handover_rl_r8: assert property (@(posedge clk) disable iff (rst)
      (own_r[i] && rg_i && req_l[i] && !lg_i) |=> own_l[i]);
  end
endmodule

bind dual_sema_bank dual_sema_bank_chk #(
  .NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/dual_sema_bank_test.sv
`timescale 1ns/1ps
module dual_sema_bank_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 0, l_we = 0, r_sel = 0, r_we = 0;
  logic [2:0] l_idx = 0, r_idx = 0;
  logic [15:0] l_din = 0, r_din = 0;
  logic [15:0] l_dout, r_dout;

  int vectors = 0;
  int fails = 0;

  // reference model: request flags and owner (0 none, 1 left, 2 right)
  bit ref_l[8];
  bit ref_r[8];
  int ref_own[8];

  always #4 clk = ~clk;  // 125 MHz

  dual_sema_bank uut (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_we(l_we), .l_idx(l_idx), .l_din(l_din), .l_dout(l_dout),
    .r_sel(r_sel), .r_we(r_we), .r_idx(r_idx), .r_din(r_din), .r_dout(r_dout)
  );

  function automatic logic [15:0] exp_dout(int side, logic s, logic w, logic [2:0] i);
    if (s && !w) return (ref_own[i] == side) ? 16'h0000 : 16'hFFFF;
    return 16'hFFFF;
  endfunction

  task automatic compare(string tag, string port, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s port %s: got %h expected %h at %0t", tag, port, act, exp, $time);
    end
  endtask

  task automatic model_update(logic rs);
    if (rs) begin
      foreach (ref_own[k]) begin ref_l[k] = 0; ref_r[k] = 0; ref_own[k] = 0; end
      return;
    end
    if (l_sel && l_we) ref_l[l_idx] = !l_din[0];
    if (r_sel && r_we) ref_r[r_idx] = !r_din[0];
    foreach (ref_own[k]) begin
      if (ref_own[k] == 1 && !ref_l[k]) ref_own[k] = 0;
      if (ref_own[k] == 2 && !ref_r[k]) ref_own[k] = 0;
      if (ref_own[k] == 0) begin
        if (ref_l[k])      ref_own[k] = 1;
        else if (ref_r[k]) ref_own[k] = 2;
      end
    end
  endtask

  task automatic step(string tag,
                      logic ls, logic lw, logic [2:0] li, logic [15:0] ld,
                      logic rs_, logic rw, logic [2:0] ri, logic [15:0] rd);
    @(negedge clk);
    l_sel = ls; l_we = lw; l_idx = li; l_din = ld;
    r_sel = rs_; r_we = rw; r_idx = ri; r_din = rd;
    #1;
    if (!rst) begin
      compare(tag, "left",  l_dout, exp_dout(1, ls, lw, li));
      compare(tag, "right", r_dout, exp_dout(2, rs_, rw, ri));
    end
    @(posedge clk);
    model_update(rst);
  endtask

  // convenience: left-only / right-only / idle
  task automatic lop(string tag, logic w, logic [2:0] i, logic [15:0] d);
    step(tag, 1, w, i, d, 0, 0, 0, 16'h0);
  endtask
  task automatic rop(string tag, logic w, logic [2:0] i, logic [15:0] d);
    step(tag, 0, 0, 0, 16'h0, 1, w, i, d);
  endtask
  task automatic both_read(string tag, logic [2:0] i);
    step(tag, 1, 0, i, 16'h0, 1, 0, i, 16'h0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst = 1;
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); rst = 0;
    // R10 / R1: every semaphore free after reset, idle outputs all ones
    step("R3", 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) both_read("R10", 3'(i));

    // R5: left claims sem 0, reads zero; right reads one (R4)
    lop("R2", 1, 3'd0, 16'h0000);
    both_read("R5", 3'd0);
    // R6: right asks later, stays locked out
    rop("R6", 1, 3'd0, 16'h0000);
    both_read("R6", 3'd0);
    // R3: repeated reads change nothing
    both_read("R3", 3'd0);
    lop("R3", 0, 3'd0, 16'h0000);
    both_read("R3", 3'd0);
    // R8: left releases, right was waiting
    lop("R8", 1, 3'd0, 16'h0001);
    both_read("R8", 3'd0);
    rop("R2", 1, 3'd0, 16'hFFFF);
    both_read("R2", 3'd0);

    // R7: tie on sem 3
    step("R7", 1, 1, 3'd3, 16'h0000, 1, 1, 3'd3, 16'h0000);
    both_read("R7", 3'd3);
    // R11: right withdraws, left releases -> nobody owns
    rop("R11", 1, 3'd3, 16'h0001);
    lop("R11", 1, 3'd3, 16'h0001);
    both_read("R11", 3'd3);
    rop("R11", 0, 3'd3, 16'h0);

    // R9: upper data bits ignored
    lop("R9", 1, 3'd5, 16'hFFFE);
    both_read("R9", 3'd5);
    lop("R9", 1, 3'd5, 16'h8001);
    both_read("R9", 3'd5);
    rop("R9", 1, 3'd5, 16'h7FFE);
    both_read("R9", 3'd5);
    rop("R9", 1, 3'd5, 16'h0003);

    // R1: independent semaphores held by different sides
    step("R1", 1, 1, 3'd1, 16'h0, 1, 1, 3'd2, 16'h0);
    both_read("R1", 3'd1);
    both_read("R1", 3'd2);
    step("R1", 1, 0, 3'd2, 16'h0, 1, 0, 3'd1, 16'h0);
    for (int i = 0; i < 8; i++) both_read("R1", 3'(i));

    // random mix, heavy index collisions (R4)
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] li, ri;
      logic [15:0] ld, rd;
      li = 3'($urandom_range(0, 3));
      ri = ($urandom_range(0, 1) == 0) ? li : 3'($urandom_range(0, 7));
      ld = 16'($urandom);
      rd = 16'($urandom);
      step("R4", 1'($urandom_range(0, 3) != 0), 1'($urandom), li, ld,
                 1'($urandom_range(0, 3) != 0), 1'($urandom), ri, rd);
    end

    // R10: reset mid-run frees everything again
    @(negedge clk); rst = 1;
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); rst = 0;
    for (int i = 0; i < 8; i++) both_read("R10", 3'(i));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule